// File: doc/BRIEF.md
# Multiphase Clock Post-Divider

This block is the digital output stage of a clock generator. It receives three oscillator clock phases that are 120 degrees apart. It produces one main output clock and two extra phase outputs. In divided mode every output is its own phase clock divided by a selectable power of two, with a 50% duty cycle. In direct mode each output carries its raw oscillator phase, and the duty cycle is whatever the oscillator gives.

The analog loop sits outside this block and reports lock on an input. Before lock, the two extra phase dividers run free, so their phase relative to the main output is unknown. On the rising edge of lock, seen through a synchronizer in each extra domain, each extra divider performs a single load that copies the count and the active configuration of the main divider. From then on, each extra divider lags the main divider by exactly its own phase offset.

A power-down input stops the whole stage at once. It resets every domain, forces the lock indication low and holds every output low. When power-down is released, dividing starts again, and the extra phases are aligned again once the synchronized lock rises.

Top module: `mpd_postdiv`

## Requirements
- R1: With `direct_en` low, every output clock has a period of 2^(sel+1) cycles of its oscillator phase and a 50% duty cycle. The code on `div_sel` is 00 for /2, 01 for /4, 10 for /8 and 11 for /16.
- R2: With `direct_en` high, every enabled output follows its own oscillator phase with no division.
- R3: While `ph_en` is low, `clk_ph1` and `clk_ph2` stay low. This takes effect within three cycles of their own phase clock.
- R4: While `ph_en` is high and lock is low, `clk_ph1` and `clk_ph2` divide their own phase clocks by the selected ratio.
- R5: A few cycles after `lock_in` rises, and from then on, every rising edge of `clk_ph1` comes one third of an oscillator period after a rising edge of `clk_main`. Every rising edge of `clk_ph2` comes two thirds of an oscillator period after that same `clk_main` edge.
- R6: A change of `div_sel` or `direct_en` takes effect only when the main divider's count wraps to zero. The half period in progress finishes at its old length, and the first half period under the new setting starts low.
- R7: While `pwr_down` is high, `clk_main`, `clk_ph1`, `clk_ph2` and `lock_out` are low. This takes effect at once, without waiting for a clock edge.
- R8: While `pwr_down` is low, `lock_out` equals `lock_in` delayed by two rising edges of `osc_clk0`.
- R9: After `pwr_down` falls, the outputs divide again and `lock_out` returns. The extra phases become aligned again as in R5 once the synchronized lock rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk0 | input | 1 | Oscillator phase at 0 degrees; clocks the main divider |
| osc_clk1 | input | 1 | Oscillator phase at 120 degrees |
| osc_clk2 | input | 1 | Oscillator phase at 240 degrees |
| pwr_down | input | 1 | Power-down: asynchronous assert, released per domain through a synchronizer |
| lock_in | input | 1 | Lock report from the analog loop, asynchronous |
| ph_en | input | 1 | Enables the two extra phase outputs |
| div_sel | input | 2 | Division select: 00=/2, 01=/4, 10=/8, 11=/16 |
| direct_en | input | 1 | Passes the oscillator phases straight through |
| clk_main | output | 1 | Main output clock |
| clk_ph1 | output | 1 | Extra output at 120 degrees |
| clk_ph2 | output | 1 | Extra output at 240 degrees |
| lock_out | output | 1 | Synchronized lock indication, low in power-down |

## Verification
If the count in an extra divider is wrong after the alignment load, the next rising edge of `clk_ph1` or `clk_ph2` no longer lands one or two thirds of an oscillator period after `clk_main`. That error appears within one output period of the load. A terminal-count decode or a configuration capture that happens at the wrong time shows up as a short or long half period at the moment `div_sel` changes, or as a wrong period once the new setting has settled. A synchronizer of the wrong depth moves the rise of `lock_out` by whole cycles. A faulty power-down path leaves an output or `lock_out` high while `pwr_down` is asserted.

// File: rtl/mpd_pkg.sv
`timescale 1ns/1ps
package mpd_pkg;
  localparam int unsigned SEL_W  = 2;
  localparam int unsigned CNT_W  = 1 << SEL_W;
  localparam int unsigned SYNC_D = 2;
  localparam int unsigned RST_D  = 2;
  localparam int unsigned NPH    = 3;

  typedef logic [SEL_W-1:0] sel_t;
  typedef logic [CNT_W-1:0] cnt_t;

  typedef struct packed {
    logic direct;
    sel_t sel;
  } cfg_t;

  // last count value of one output period: 2^(sel+1)-1
  function automatic cnt_t last_count(sel_t s);
    return cnt_t'((64'd1 << (int'(s) + 1)) - 64'd1);
  endfunction

  // count at which the output goes high: 2^sel
  function automatic cnt_t half_count(sel_t s);
    return cnt_t'(64'd1 << s);
  endfunction
endpackage

// File: rtl/mpd_rst_sync.sv
`timescale 1ns/1ps
module mpd_rst_sync #(
  parameter int unsigned DEPTH = mpd_pkg::RST_D
) (
  input  logic clk_i,
  input  logic pd_i,
  output logic rst_o
);
  logic [DEPTH-1:0] ff_q;

  // asserts with power-down at once, releases DEPTH edges later
  always_ff @(posedge clk_i or posedge pd_i) begin
    if (pd_i) ff_q <= '1;
    else      ff_q <= {ff_q[DEPTH-2:0], 1'b0};
  end

  assign rst_o = ff_q[DEPTH-1];
endmodule

// File: rtl/mpd_sync.sv
`timescale 1ns/1ps
module mpd_sync #(
  parameter int unsigned W     = 1,
  parameter int unsigned DEPTH = mpd_pkg::SYNC_D
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [DEPTH-1:0][W-1:0] st_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) st_q <= '0;
    else       st_q <= {st_q[DEPTH-2:0], d_i};
  end

  assign q_o = st_q[DEPTH-1];
endmodule

// File: rtl/mpd_phase_div.sv
`timescale 1ns/1ps
module mpd_phase_div
  import mpd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_i,
  input  logic en_i,
  input  logic load_i,
  input  cfg_t src_cfg_i,
  input  cnt_t peer_cnt_i,
  input  cfg_t peer_cfg_i,
  output cnt_t cnt_o,
  output cfg_t cfg_o,
  output logic clk_o
);
  cnt_t cnt_q;
  cfg_t cfg_q;
  logic out_q;
  logic aligned_q;
  logic term;
  cnt_t cnt_inc;

  assign term    = (cnt_q == last_count(cfg_q.sel));
  assign cnt_inc = cnt_q + cnt_t'(1);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q     <= '0;
      cfg_q     <= src_cfg_i;
      out_q     <= 1'b0;
      aligned_q <= 1'b0;
    end else if (load_i) begin
      cnt_q     <= peer_cnt_i;
      cfg_q     <= peer_cfg_i;
      out_q     <= peer_cnt_i[peer_cfg_i.sel];
      aligned_q <= 1'b1;
    end else if (term) begin
      // restart and pick up a new setting only at the period boundary
      cnt_q <= '0;
      cfg_q <= src_cfg_i;
      out_q <= 1'b0;
    end else begin
      cnt_q <= cnt_inc;
      out_q <= cnt_inc[cfg_q.sel];
    end
  end

  assign clk_o = !rst_i && en_i && (cfg_q.direct ? clk_i : out_q);
  assign cnt_o = cnt_q;
  assign cfg_o = cfg_q;

  // R6: the active setting changes only with a counter restart or a load
  p_cfg_restart_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(cfg_q) |-> (cnt_q == '0) || $past(load_i));

  // R1: the divided output rises exactly at the half-period count
  p_duty_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(out_q) |-> (cnt_q == half_count(cfg_q.sel)) || $past(load_i));

  // R5: once aligned, this divider replays the main divider one phase later
  p_phase_track_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    aligned_q |=> (cnt_q == $past(peer_cnt_i)) && (cfg_q == $past(peer_cfg_i)));
endmodule

// File: rtl/mpd_postdiv.sv
`timescale 1ns/1ps
module mpd_postdiv
  import mpd_pkg::*;
(
  input  logic             osc_clk0,
  input  logic             osc_clk1,
  input  logic             osc_clk2,
  input  logic             pwr_down,
  input  logic             lock_in,
  input  logic             ph_en,
  input  logic [SEL_W-1:0] div_sel,
  input  logic             direct_en,
  output logic             clk_main,
  output logic             clk_ph1,
  output logic             clk_ph2,
  output logic             lock_out
);
  logic [NPH-1:0] osc_v;
  logic [NPH-1:0] rst_v;
  logic [NPH-1:0] lk_s;
  logic [NPH-1:0] clk_v;
  cnt_t           cnt_a [NPH];
  cfg_t           cfg_a [NPH];
  cfg_t           src_cfg;

  assign osc_v   = {osc_clk2, osc_clk1, osc_clk0};
  assign src_cfg = cfg_t'({direct_en, div_sel});

  for (genvar g = 0; g < NPH; g++) begin : g_ph
    logic [1:0] sq_w;
    logic       lk_d_q;
    logic       load_w;

    mpd_rst_sync u_rst (
      .clk_i (osc_v[g]),
      .pd_i  (pwr_down),
      .rst_o (rst_v[g])
    );

    mpd_sync #(.W(2)) u_sync (
      .clk_i (osc_v[g]),
      .rst_i (rst_v[g]),
      .d_i   ({lock_in, ph_en}),
      .q_o   (sq_w)
    );

    always_ff @(posedge osc_v[g]) begin
      if (rst_v[g]) lk_d_q <= 1'b0;
      else          lk_d_q <= sq_w[1];
    end

    // extra phases load the main state once per synchronized lock rise
    assign load_w  = (g != 0) && sq_w[1] && !lk_d_q;
    assign lk_s[g] = sq_w[1];

    mpd_phase_div u_div (
      .clk_i      (osc_v[g]),
      .rst_i      (rst_v[g]),
      .en_i       ((g == 0) ? 1'b1 : sq_w[0]),
      .load_i     (load_w),
      .src_cfg_i  ((g == 0) ? src_cfg : cfg_a[0]),
      .peer_cnt_i (cnt_a[0]),
      .peer_cfg_i (cfg_a[0]),
      .cnt_o      (cnt_a[g]),
      .cfg_o      (cfg_a[g]),
      .clk_o      (clk_v[g])
    );
  end

  assign clk_main = clk_v[0];
  assign clk_ph1  = clk_v[1];
  assign clk_ph2  = clk_v[2];
  assign lock_out = lk_s[0] && !rst_v[0];

  // R8: lock indication is the lock input two main-phase edges late
  p_lock_sync_r8: assert property (@(posedge osc_clk0) disable iff (rst_v[0])
    $rose(lock_out) |-> $past(lock_in, 2));
endmodule

// File: tb/mpd_postdiv_tb_top.sv
`timescale 1ns/1ps
module mpd_postdiv_tb_top;
  logic osc0 = 1'b0, osc1 = 1'b0, osc2 = 1'b0;
  logic pwr_down = 1'b1, lock_in = 1'b0, ph_en = 1'b0, direct_en = 1'b0;
  logic [1:0] div_sel = 2'b00;
  logic clk_main, clk_ph1, clk_ph2, lock_out;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  initial forever #5 osc0 = ~osc0;
  initial begin #3.333; forever #5 osc1 = ~osc1; end
  initial begin #6.667; forever #5 osc2 = ~osc2; end

  mpd_postdiv dut_i (
    .osc_clk0(osc0), .osc_clk1(osc1), .osc_clk2(osc2),
    .pwr_down(pwr_down), .lock_in(lock_in), .ph_en(ph_en),
    .div_sel(div_sel), .direct_en(direct_en),
    .clk_main(clk_main), .clk_ph1(clk_ph1), .clk_ph2(clk_ph2),
    .lock_out(lock_out)
  );

  task automatic chk_bit(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic chk_num(string req, string what, real act, real exp);
    n_chk++;
    if (act - exp > 0.01 || exp - act > 0.01) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0.3f expected=%0.3f", req, what, act, exp);
    end
  endtask

  task automatic wait_edge(int w, bit rise);
    case (w)
      0: if (rise) @(posedge clk_main); else @(negedge clk_main);
      1: if (rise) @(posedge clk_ph1);  else @(negedge clk_ph1);
      default: if (rise) @(posedge clk_ph2); else @(negedge clk_ph2);
    endcase
  endtask

  task automatic meas(int w, output real per, output real hi);
    realtime a, b, c;
    wait_edge(w, 1'b1); a = $realtime;
    wait_edge(w, 1'b0); b = $realtime;
    wait_edge(w, 1'b1); c = $realtime;
    per = c - a;
    hi  = b - a;
  endtask

  task automatic set_cfg(logic [1:0] s, logic d);
    @(negedge osc0);
    div_sel   = s;
    direct_en = d;
    repeat (40) @(negedge osc0);
  endtask

  task automatic count_high(int n, output int h0, output int h1, output int h2);
    h0 = 0; h1 = 0; h2 = 0;
    repeat (n) begin
      #3.1;
      if (clk_main) h0++;
      if (clk_ph1)  h1++;
      if (clk_ph2)  h2++;
    end
  endtask

  task automatic check_align(string req);
    realtime t0, t1, t2;
    wait_edge(0, 1'b1); t0 = $realtime;
    wait_edge(1, 1'b1); t1 = $realtime;
    wait_edge(2, 1'b1); t2 = $realtime;
    chk_num(req, "ph1 trail ns", t1 - t0, 3.333);
    chk_num(req, "ph2 trail ns", t2 - t0, 6.667);
  endtask

  task automatic t_reset();
    int h0, h1, h2;
    repeat (8) @(negedge osc0);
    count_high(20, h0, h1, h2);
    chk_bit("R7", "clk_main high in pd", h0 != 0, 1'b0);
    chk_bit("R7", "clk_ph1 high in pd", h1 != 0, 1'b0);
    chk_bit("R7", "clk_ph2 high in pd", h2 != 0, 1'b0);
    chk_bit("R7", "lock_out in pd", lock_out, 1'b0);
  endtask

  task automatic t_ratios();
    real p, h;
    @(negedge osc0) pwr_down = 1'b0;
    for (int s = 0; s < 4; s++) begin
      set_cfg(s[1:0], 1'b0);
      meas(0, p, h);
      chk_num("R1", "main period", p, 10.0 * (1 << (s + 1)));
      chk_num("R1", "main high time", h, 5.0 * (1 << (s + 1)));
    end
  endtask

  task automatic t_ph_off();
    int h0, h1, h2;
    set_cfg(2'b00, 1'b0);
    count_high(40, h0, h1, h2);
    chk_bit("R3", "clk_ph1 high while disabled", h1 != 0, 1'b0);
    chk_bit("R3", "clk_ph2 high while disabled", h2 != 0, 1'b0);
  endtask

  task automatic t_unlocked();
    real p, h;
    @(negedge osc0) ph_en = 1'b1;
    set_cfg(2'b01, 1'b0);
    meas(1, p, h);
    chk_num("R4", "ph1 period unlocked", p, 40.0);
    meas(2, p, h);
    chk_num("R4", "ph2 period unlocked", p, 40.0);
  endtask

  task automatic t_lock();
    @(negedge osc0) lock_in = 1'b1;
    @(negedge osc0) chk_bit("R8", "lock_out after one edge", lock_out, 1'b0);
    @(negedge osc0) chk_bit("R8", "lock_out after two edges", lock_out, 1'b1);
    repeat (10) @(negedge osc0);
    set_cfg(2'b10, 1'b0);
    check_align("R5");
    set_cfg(2'b00, 1'b0);
    check_align("R5");
  endtask

  task automatic t_switch();
    realtime t0, t1, t2;
    set_cfg(2'b11, 1'b0);
    wait_edge(0, 1'b1); t0 = $realtime;
    repeat (2) @(negedge osc0);
    div_sel = 2'b00;
    wait_edge(0, 1'b0); t1 = $realtime;
    chk_num("R6", "high half kept old length", t1 - t0, 80.0);
    wait_edge(0, 1'b1); t2 = $realtime;
    chk_num("R6", "first new low half", t2 - t1, 10.0);
  endtask

  task automatic t_direct();
    real p, h;
    set_cfg(2'b00, 1'b1);
    meas(0, p, h);
    chk_num("R2", "main period direct", p, 10.0);
    chk_num("R2", "main high direct", h, 5.0);
    meas(1, p, h);
    chk_num("R2", "ph1 period direct", p, 10.0);
    set_cfg(2'b01, 1'b0);
  endtask

  task automatic t_pd();
    int h0, h1, h2;
    real p, h;
    @(negedge osc0) pwr_down = 1'b1;
    #1;
    chk_bit("R7", "lock_out at pd", lock_out, 1'b0);
    count_high(30, h0, h1, h2);
    chk_bit("R7", "any output high in pd", (h0 + h1 + h2) != 0, 1'b0);
    @(negedge osc0) pwr_down = 1'b0;
    repeat (10) @(negedge osc0);
    chk_bit("R9", "lock_out after release", lock_out, 1'b1);
    meas(0, p, h);
    chk_num("R9", "main period after release", p, 40.0);
    check_align("R9");
  endtask

  initial begin
    t_reset();
    t_ratios();
    t_ph_off();
    t_unlocked();
    t_lock();
    t_switch();
    t_direct();
    t_pd();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule